// File: doc/BRIEF.md
# Quadratic Per-Pixel Color Corrector

This block sits in a raw-image pipeline and corrects the white balance of color-filter-array samples one at a time, before any demosaicing. Each incoming sample carries a two-bit color tag. A red sample is replaced by a second-order polynomial of its own value built from a red coefficient pair. A blue sample gets the same treatment with a blue pair. Green samples leave the block exactly as they came in. The output is the same mosaic as the input, sample for sample, with the tag and the frame-start flag carried along.

The coefficients are signed fixed-point numbers with `FRAC` fractional bits. The squared term is normalised by the full pixel range, so a linear coefficient of 1.0 together with a square coefficient of 0 leaves a sample unchanged. Software may rewrite the coefficients at any time. A write only fills a holding copy, and the working set takes it over on the next accepted frame-start sample. A whole frame is therefore always corrected with one consistent set.

Both sides use a valid/ready handshake. The datapath is a fixed three-stage pipeline: square, products, then sum and clamp. When the consumer withholds ready, the whole pipeline freezes.

Top module: `wb_quad_corrector`

## Requirements
- R1: A sample tagged red (tag 0) leaves as clamp(floor((U_r·I² + V_r·I·2^W) / 2^(FRAC+W))), where U_r and V_r are the red square and linear coefficients, read as signed two's complement.
- R2: A sample tagged blue (tag 2) uses the same formula with the blue coefficients U_b and V_b, independently of the red pair.
- R3: A sample tagged green (tag 1 or tag 3) leaves with its input value unchanged, whatever the coefficients are.
- R4: A result above 2^W−1 leaves as 2^W−1, and a negative result leaves as 0.
- R5: An accepted sample appears on the output three clock edges after the edge that accepted it when ready stays high. Samples leave in input order, each with its own tag and frame-start flag.
- R6: A coefficient write (cfg_we high) takes effect starting with the next accepted sample that has s_sof high, that sample included. Samples accepted before it still use the previous set.
- R7: While m_valid is high and m_ready is low, m_valid, m_pix, m_color and m_sof hold their values, s_ready is low, and no sample is lost or duplicated.
- R8: After reset the output is empty (m_valid low), and the working and holding coefficients are U=0 and V=1.0, so red and blue samples pass unchanged until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the four coefficients into the holding copy |
| cfg_red_sq | input | CW | Red square coefficient, signed, FRAC fractional bits |
| cfg_red_lin | input | CW | Red linear coefficient, signed |
| cfg_blu_sq | input | CW | Blue square coefficient, signed |
| cfg_blu_lin | input | CW | Blue linear coefficient, signed |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_pix | input | W | Raw input sample |
| s_color | input | 2 | Color tag: 0 red, 1 green, 2 blue, 3 green |
| s_sof | input | 1 | First sample of a frame |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer takes the output sample |
| m_pix | output | W | Corrected sample |
| m_color | output | 2 | Color tag of the output sample |
| m_sof | output | 1 | Frame-start flag of the output sample |

## Verification
Every accepted sample is due on the output exactly three edges after acceptance while ready stays high. Under backpressure it is due at the first handshake after the samples ahead of it. The bench therefore keeps a queue of expected values, each with the cycle it was accepted in. It compares at each output handshake, half a cycle after the edge, and checks the three-edge distance in the phases without backpressure. A stalled output is compared one cycle later against what was sampled during the stall. Coefficient writes become visible at the next frame-start acceptance, so the bench's own model switches its working set on that acceptance and not at the write.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  typedef enum logic [1:0] {
    CFA_RED   = 2'd0,
    CFA_GRN_A = 2'd1,
    CFA_BLUE  = 2'd2,
    CFA_GRN_B = 2'd3
  } cfa_e;

  function automatic logic is_green(input logic [1:0] tag);
    return (tag == CFA_GRN_A) || (tag == CFA_GRN_B);
  endfunction

  function automatic logic is_blue(input logic [1:0] tag);
    return tag == CFA_BLUE;
  endfunction
endpackage

// File: rtl/wbq_gain_bank.sv
module wbq_gain_bank #(
  parameter int CW   = 12,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_red_sq,
  input  logic [CW-1:0] cfg_red_lin,
  input  logic [CW-1:0] cfg_blu_sq,
  input  logic [CW-1:0] cfg_blu_lin,
  input  logic          swap,
  input  logic [1:0]    tag,
  output logic [CW-1:0] sel_sq,
  output logic [CW-1:0] sel_lin,
  output logic [4*CW-1:0] act_bus
);
  import wbq_pkg::*;

  localparam logic [CW-1:0] UNITY = CW'(1 << FRAC);
  localparam int NSET = 4;

  // index 0 red sq, 1 red lin, 2 blue sq, 3 blue lin
  logic [CW-1:0] shd [NSET];
  logic [CW-1:0] act [NSET];
  logic [CW-1:0] cfg_in [NSET];

  assign cfg_in[0] = cfg_red_sq;
  assign cfg_in[1] = cfg_red_lin;
  assign cfg_in[2] = cfg_blu_sq;
  assign cfg_in[3] = cfg_blu_lin;

  for (genvar g = 0; g < NSET; g++) begin : g_set
    localparam logic [CW-1:0] RST_VAL = (g % 2 == 1) ? UNITY : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[g] <= RST_VAL;
        act[g] <= RST_VAL;
      end else begin
        if (cfg_we) shd[g] <= cfg_in[g];
        if (swap)   act[g] <= shd[g];
      end
    end
    assign act_bus[g*CW +: CW] = act[g];
  end

  logic [CW-1:0] cur [NSET];
  always_comb begin
    for (int k = 0; k < NSET; k++) cur[k] = swap ? shd[k] : act[k];
    sel_sq  = is_blue(tag) ? cur[2] : cur[0];
    sel_lin = is_blue(tag) ? cur[3] : cur[1];
  end
endmodule

// File: rtl/wbq_sq_stage.sv
module wbq_sq_stage #(
  parameter int W  = 8,
  parameter int CW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           in_valid,
  input  logic [W-1:0]   in_pix,
  input  logic [1:0]     in_tag,
  input  logic           in_sof,
  input  logic [CW-1:0]  in_cu,
  input  logic [CW-1:0]  in_cv,
  output logic           out_valid,
  output logic [W-1:0]   out_pix,
  output logic [1:0]     out_tag,
  output logic           out_sof,
  output logic [2*W-1:0] out_sq,
  output logic [CW-1:0]  out_cu,
  output logic [CW-1:0]  out_cv
);
  function automatic logic [2*W-1:0] square(input logic [W-1:0] p);
    logic [2*W-1:0] e;
    e = {{W{1'b0}}, p};
    return e * e;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_tag   <= '0;
      out_sof   <= 1'b0;
      out_sq    <= '0;
      out_cu    <= '0;
      out_cv    <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_pix   <= in_pix;
      out_tag   <= in_tag;
      out_sof   <= in_sof & in_valid;
      out_sq    <= square(in_pix);
      out_cu    <= in_cu;
      out_cv    <= in_cv;
    end
  end
endmodule

// File: rtl/wbq_mul_stage.sv
module wbq_mul_stage #(
  parameter int W  = 8,
  parameter int CW = 12,
  localparam int PW = CW + 2*W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_pix,
  input  logic [1:0]           in_tag,
  input  logic                 in_sof,
  input  logic [2*W-1:0]       in_sq,
  input  logic [CW-1:0]        in_cu,
  input  logic [CW-1:0]        in_cv,
  output logic                 out_valid,
  output logic [W-1:0]         out_pix,
  output logic [1:0]           out_tag,
  output logic                 out_sof,
  output logic signed [PW-1:0] out_pu,
  output logic signed [PW-1:0] out_pv
);
  function automatic logic signed [PW-1:0] sq_term(input logic [CW-1:0] c,
                                                    input logic [2*W-1:0] s);
    logic signed [PW-1:0] a, b;
    a = PW'($signed(c));
    b = PW'($signed({1'b0, s}));
    return a * b;
  endfunction

  function automatic logic signed [PW-1:0] lin_term(input logic [CW-1:0] c,
                                                     input logic [W-1:0] p);
    logic signed [PW-1:0] a, b;
    a = PW'($signed(c));
    b = PW'($signed({1'b0, p}));
    return (a * b) <<< W;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_tag   <= '0;
      out_sof   <= 1'b0;
      out_pu    <= '0;
      out_pv    <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_pix   <= in_pix;
      out_tag   <= in_tag;
      out_sof   <= in_sof;
      out_pu    <= sq_term(in_cu, in_sq);
      out_pv    <= lin_term(in_cv, in_pix);
    end
  end
endmodule

// File: rtl/wbq_sum_stage.sv
module wbq_sum_stage #(
  parameter int W    = 8,
  parameter int CW   = 12,
  parameter int FRAC = 8,
  localparam int PW  = CW + 2*W + 1,
  localparam int SW  = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_pix,
  input  logic [1:0]           in_tag,
  input  logic                 in_sof,
  input  logic signed [PW-1:0] in_pu,
  input  logic signed [PW-1:0] in_pv,
  output logic                 out_valid,
  output logic [W-1:0]         out_pix,
  output logic [1:0]           out_tag,
  output logic                 out_sof
);
  import wbq_pkg::*;

  localparam int SHIFT = FRAC + W;
  localparam logic signed [SW-1:0] TOP = SW'((1 << W) - 1);

  function automatic logic [W-1:0] sum_clamp(input logic signed [PW-1:0] a,
                                             input logic signed [PW-1:0] b);
    logic signed [SW-1:0] s;
    s = (SW'(a) + SW'(b)) >>> SHIFT;
    if (s < 0)        return '0;
    else if (s > TOP) return {W{1'b1}};
    else              return W'(s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_tag   <= '0;
      out_sof   <= 1'b0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_pix   <= is_green(in_tag) ? in_pix : sum_clamp(in_pu, in_pv);
      out_tag   <= in_tag;
      out_sof   <= in_sof;
    end
  end
endmodule

// File: rtl/wb_quad_corrector.sv
module wb_quad_corrector #(
  parameter int W    = 8,
  parameter int CW   = 12,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_red_sq,
  input  logic [CW-1:0] cfg_red_lin,
  input  logic [CW-1:0] cfg_blu_sq,
  input  logic [CW-1:0] cfg_blu_lin,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [W-1:0]  s_pix,
  input  logic [1:0]    s_color,
  input  logic          s_sof,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [W-1:0]  m_pix,
  output logic [1:0]    m_color,
  output logic          m_sof
);
  localparam int PW = CW + 2*W + 1;

  // named events for the checker
  logic            adv_w;
  logic            in_fire_w;
  logic            out_fire_w;
  logic            gain_swap_w;
  logic [4*CW-1:0] act_bus_w;

  logic [CW-1:0] sel_sq, sel_lin;

  logic           v1, sof1;
  logic [W-1:0]   pix1;
  logic [1:0]     tag1;
  logic [2*W-1:0] sq1;
  logic [CW-1:0]  cu1, cv1;

  logic                 v2, sof2;
  logic [W-1:0]         pix2;
  logic [1:0]           tag2;
  logic signed [PW-1:0] pu2, pv2;

  assign adv_w       = !m_valid || m_ready;
  assign s_ready     = adv_w;
  assign in_fire_w   = s_valid && s_ready;
  assign out_fire_w  = m_valid && m_ready;
  assign gain_swap_w = in_fire_w && s_sof;

  wbq_gain_bank #(.CW(CW), .FRAC(FRAC)) u_gain (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_red_sq(cfg_red_sq), .cfg_red_lin(cfg_red_lin),
    .cfg_blu_sq(cfg_blu_sq), .cfg_blu_lin(cfg_blu_lin),
    .swap(gain_swap_w), .tag(s_color),
    .sel_sq(sel_sq), .sel_lin(sel_lin), .act_bus(act_bus_w)
  );

  wbq_sq_stage #(.W(W), .CW(CW)) u_st1 (
    .clk(clk), .rst_n(rst_n), .adv(adv_w),
    .in_valid(s_valid), .in_pix(s_pix), .in_tag(s_color), .in_sof(s_sof),
    .in_cu(sel_sq), .in_cv(sel_lin),
    .out_valid(v1), .out_pix(pix1), .out_tag(tag1), .out_sof(sof1),
    .out_sq(sq1), .out_cu(cu1), .out_cv(cv1)
  );

  wbq_mul_stage #(.W(W), .CW(CW)) u_st2 (
    .clk(clk), .rst_n(rst_n), .adv(adv_w),
    .in_valid(v1), .in_pix(pix1), .in_tag(tag1), .in_sof(sof1),
    .in_sq(sq1), .in_cu(cu1), .in_cv(cv1),
    .out_valid(v2), .out_pix(pix2), .out_tag(tag2), .out_sof(sof2),
    .out_pu(pu2), .out_pv(pv2)
  );

  wbq_sum_stage #(.W(W), .CW(CW), .FRAC(FRAC)) u_st3 (
    .clk(clk), .rst_n(rst_n), .adv(adv_w),
    .in_valid(v2), .in_pix(pix2), .in_tag(tag2), .in_sof(sof2),
    .in_pu(pu2), .in_pv(pv2),
    .out_valid(m_valid), .out_pix(m_pix), .out_tag(m_color), .out_sof(m_sof)
  );
endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
  parameter int W  = 8,
  parameter int CW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_ready,
  input logic            m_valid,
  input logic            m_ready,
  input logic [W-1:0]    m_pix,
  input logic [1:0]      m_color,
  input logic            m_sof,
  input logic            in_fire_w,
  input logic            out_fire_w,
  input logic            gain_swap_w,
  input logic [4*CW-1:0] act_bus_w
);
  logic [2:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 3'(in_fire_w) - 3'(out_fire_w);
  end

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix) && $stable(m_color) && $stable(m_sof)));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (m_valid && !m_ready));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_swap_w |=> $stable(act_bus_w));

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd3);

  // R5
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (occ != 3'd0));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !m_valid);
endmodule

bind wb_quad_corrector wbq_checker #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_pix(m_pix), .m_color(m_color), .m_sof(m_sof),
  .in_fire_w(in_fire_w), .out_fire_w(out_fire_w),
  .gain_swap_w(gain_swap_w), .act_bus_w(act_bus_w)
);

// File: tb/wb_quad_corrector_test.sv
module wb_quad_corrector_test;
  localparam int PERIOD = 10;
  localparam int W = 8, CW = 12, FRAC = 8;
  localparam int QN = 8192;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CW-1:0] cfg_red_sq = 0, cfg_red_lin = 0, cfg_blu_sq = 0, cfg_blu_lin = 0;
  logic s_valid = 0, s_sof = 0, m_ready = 0;
  logic [W-1:0] s_pix = 0;
  logic [1:0] s_color = 0;
  logic s_ready, m_valid, m_sof;
  logic [W-1:0] m_pix;
  logic [1:0] m_color;

  wb_quad_corrector #(.W(W), .CW(CW), .FRAC(FRAC)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_pix [QN];
  int exp_tag [QN];
  int exp_sof [QN];
  int exp_cyc [QN];
  int rd = 0, wr = 0;
  int sh_u[2], sh_v[2], ac_u[2], ac_v[2];
  bit check_lat = 0;
  int stall_mode = 0;
  bit prev_stall = 0;
  logic [W-1:0] st_pix;
  logic [1:0] st_tag;
  logic st_sof;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int model(int p, int c, int u, int v);
    longint t;
    if (c == 1 || c == 3) return p;
    t = longint'(u) * p * p + longint'(v) * p * (1 << W);
    t = t >>> (FRAC + W);
    if (t < 0) return 0;
    if (t > (1 << W) - 1) return (1 << W) - 1;
    return int'(t);
  endfunction

  function automatic string req_of(int c, int v);
    if (c == 1 || c == 3) return "R3";
    if (v < 0 || v > 255) return "R4";
    return (c == 2) ? "R2" : "R1";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // sampled #1 after a negedge
  task automatic observe();
    if (prev_stall) begin
      check(m_valid && m_pix == st_pix && m_color == st_tag && m_sof == st_sof,
            "R7 hold", m_pix, st_pix);
    end
    if (m_valid && !m_ready) check(!s_ready, "R7 s_ready", s_ready, 0);
    prev_stall = m_valid && !m_ready;
    st_pix = m_pix; st_tag = m_color; st_sof = m_sof;
    if (m_valid && m_ready) begin
      if (rd == wr) check(0, "R7 extra output", m_pix, -1);
      else begin
        check(m_pix == exp_pix[rd], req_of(exp_tag[rd], exp_pix[rd]), m_pix, exp_pix[rd]);
        check(m_color == exp_tag[rd] && m_sof == exp_sof[rd], "R5 tag/sof",
              {m_color, m_sof}, exp_tag[rd] * 2 + exp_sof[rd]);
        if (check_lat) check(cyc - exp_cyc[rd] == 3, "R5 latency", cyc - exp_cyc[rd], 3);
        rd++;
      end
    end
  endtask

  task automatic pick_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = (stall_mode == 0) ? 1'b1 : (lfsr[2:0] > 3'd1);
  endtask

  task automatic send(int p, int c, bit sof);
    bit acc;
    do begin
      @(negedge clk);
      pick_ready();
      s_valid = 1; s_pix = W'(p); s_color = 2'(c); s_sof = sof;
      #1;
      observe();
      acc = s_ready;
      if (acc) begin
        int k;
        if (sof) begin ac_u = sh_u; ac_v = sh_v; end
        k = (c == 2) ? 1 : 0;
        exp_pix[wr] = model(p, c, ac_u[k], ac_v[k]);
        exp_tag[wr] = c; exp_sof[wr] = sof; exp_cyc[wr] = cyc;
        wr++;
      end
    end while (!acc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pick_ready();
      s_valid = 0; s_sof = 0;
      #1;
      observe();
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (rd != wr && guard < 5000) begin idle(1); guard++; end
    idle(4);
  endtask

  task automatic cfg(int ur, int vr, int ub, int vb);
    @(negedge clk);
    s_valid = 0; s_sof = 0;
    cfg_we = 1;
    cfg_red_sq = CW'(ur); cfg_red_lin = CW'(vr);
    cfg_blu_sq = CW'(ub); cfg_blu_lin = CW'(vb);
    #1; observe();
    sh_u[0] = ur; sh_v[0] = vr; sh_u[1] = ub; sh_v[1] = vb;
    @(negedge clk);
    cfg_we = 0;
    #1; observe();
  endtask

  task automatic frame();
    for (int i = 0; i < 1024; i++) send(i >> 2, i & 3, i == 0);
  endtask

  bit done = 0;

  initial begin
    sh_u = '{0, 0}; sh_v = '{256, 256}; ac_u = sh_u; ac_v = sh_v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: empty after reset
    check(m_valid == 0, "R8 reset m_valid", m_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(m_valid == 0 && s_ready == 1, "R8 after release", m_valid, 0);

    // R8 + R5: identity gains, no backpressure, latency checked
    check_lat = 1; stall_mode = 0;
    frame();
    drain();

    // R6: write mid-frame, old gains stay until next sof
    cfg(128, 192, -64, 384);
    for (int i = 0; i < 64; i++) send((i * 7) & 255, i & 3, 0);
    drain();
    check_lat = 0; stall_mode = 1;
    // R1 R2 R3 R7: new gains with backpressure
    frame();
    drain();

    // R4: saturation both ways
    cfg(2047, 2047, -2048, -2048);
    frame();
    drain();
    // R4: mixed sign, crossing zero
    cfg(-512, 640, 900, -300);
    frame();
    drain();
    check(rd == wr, "R7 count", wr - rd, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule